// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits in the first decode stage of an in-order machine that has two execution pipes. Each cycle it receives two consecutive pre-decoded instructions. The older one is in slot "old" and the younger one is in slot "yng". The block decides whether the two may enter the pipes together. The older instruction always goes to the general pipe U. The younger instruction may go to the restricted pipe V, but only when the pair passes every rule. When the pair is refused, only the older instruction issues. The younger one stays behind and becomes the older slot of the next pair, and the block reports how many instructions were consumed.

The rules are asymmetric:
- A branch may pair only from the younger slot.
- A complex (multi-cycle) instruction never pairs.
- A true register dependency between the two blocks pairing. This covers read-after-write and write-after-write.
- Flag dependencies, shared cache use and write-after-read never block pairing.
- Stack-pointer dependencies are forgiven when the older instruction is a tracked stack operation, because a separate tracker supplies the stack pointer value. A stack adjust that carries an immediate count gets no such exemption.

The decision is registered, so it appears one clock after the inputs are presented.

Top module: `pair_issue_check`

## Requirements
- R1: While reset (rst_n low) is asserted, and on the first edge after it, pair_o, u_issue_o and v_issue_o are 0 and consume_o is 0.
- R2: One clock after the inputs are presented:
  - u_issue_o equals old_vld.
  - v_issue_o and pair_o are 1 only when the pair is accepted.
  - consume_o is 2 when the pair is accepted, 1 when only the older instruction issues, and 0 when old_vld is 0. A younger instruction with no valid older one never issues.
- R3: If the older destination is a nonzero register other than the stack pointer, and the younger instruction reads it in yng_srca or yng_srcb, the pair is refused.
- R4: If both instructions write the same nonzero register, the pair is refused.
- R5: A younger instruction that writes a register the older one reads does not prevent pairing.
- R6: The class codes are: 0 ALU, 1 branch, 2 memory write, 3 tracked stack op, 4 stack adjust with immediate, 5 complex.
  - An older branch (class 1) refuses the pair.
  - A younger branch may pair.
- R7: A complex instruction (class 5) in either slot refuses the pair.
- R8: The flag read and flag write bits have no effect on the decision.
- R9: The cache-use bits have no effect on the decision, even when both are set.
- R10: The stack pointer is register SP_IDX (default 4). Classes 3 and 4 implicitly read and write it. A stack-pointer dependency (the older writes it, and the younger reads or writes it) is forgiven when the older instruction is class 3 and the younger is not class 4.
- R11: A stack-pointer dependency that involves a class-4 instruction in either slot, or an older explicit write of the stack pointer, refuses the pair.
- R12: Register 0 in a destination field means no destination and never creates a dependency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| old_vld | input | 1 | Older slot holds an instruction |
| old_cls | input | 3 | Older class code |
| old_dst | input | REG_W | Older destination register (0 = none) |
| old_srca | input | REG_W | Older first source |
| old_srcb | input | REG_W | Older second source |
| old_flg_rd | input | 1 | Older reads flags |
| old_flg_wr | input | 1 | Older writes flags |
| old_cache | input | 1 | Older uses the data cache |
| yng_vld | input | 1 | Younger slot holds an instruction |
| yng_cls | input | 3 | Younger class code |
| yng_dst | input | REG_W | Younger destination register (0 = none) |
| yng_srca | input | REG_W | Younger first source |
| yng_srcb | input | REG_W | Younger second source |
| yng_flg_rd | input | 1 | Younger reads flags |
| yng_flg_wr | input | 1 | Younger writes flags |
| yng_cache | input | 1 | Younger uses the data cache |
| pair_o | output | 1 | Both instructions issued this cycle |
| u_issue_o | output | 1 | Instruction issued to pipe U |
| v_issue_o | output | 1 | Instruction issued to pipe V |
| consume_o | output | 2 | Instructions consumed (0, 1 or 2) |

## Verification
The assertions check, on every cycle, the invariants that involve the outputs alone or a single named hazard:
- V never issues without U, and a pair always consumes two instructions.
- An older branch, a complex instruction, a detected register dependency, or an unforgiven stack-pointer conflict is always followed by a refusal.
- A flag-only or cache-only relationship on an otherwise legal pair is always followed by a pairing.

Whether the hazard detection itself is correct can only be shown by the bench's vectors. Those vectors cover write-after-read, register zero, a younger branch, the stack-op exemption and its refusal cases, and reset. Each vector states the expected decision from the rules, not from the RTL's wires.

// File: rtl/pair_pkg.sv
package pair_pkg;

  typedef enum logic [2:0] {
    CLS_ALU     = 3'd0,
    CLS_BRANCH  = 3'd1,
    CLS_MEMWR   = 3'd2,
    CLS_STACK   = 3'd3,
    CLS_STKIMM  = 3'd4,
    CLS_COMPLEX = 3'd5
  } icls_e;

  // classes that implicitly read and write the stack pointer
  function automatic logic touches_sp(input icls_e c);
    return (c == CLS_STACK) || (c == CLS_STKIMM);
  endfunction

endpackage

// File: rtl/pair_hazard.sv
module pair_hazard
  import pair_pkg::*;
#(
  parameter int REG_W  = 3,
  parameter int SP_IDX = 4
) (
  input  icls_e            o_cls,
  input  logic [REG_W-1:0] o_dst,
  input  icls_e            y_cls,
  input  logic [REG_W-1:0] y_dst,
  input  logic [REG_W-1:0] y_sa,
  input  logic [REG_W-1:0] y_sb,
  output logic             raw_gp,
  output logic             waw_gp,
  output logic             sp_dep,
  output logic             sp_exempt
);
  localparam logic [REG_W-1:0] SP_L = REG_W'(SP_IDX);

  // a general register write that another field names
  function automatic logic gp_hit(input logic [REG_W-1:0] w, input logic [REG_W-1:0] r);
    return (w != '0) && (w != SP_L) && (w == r);
  endfunction

  logic o_wr_sp, y_rd_sp, y_wr_sp;

  always_comb begin
    raw_gp    = gp_hit(o_dst, y_sa) || gp_hit(o_dst, y_sb);
    waw_gp    = gp_hit(o_dst, y_dst);
    o_wr_sp   = touches_sp(o_cls) || (o_dst == SP_L);
    y_rd_sp   = touches_sp(y_cls) || (y_sa == SP_L) || (y_sb == SP_L);
    y_wr_sp   = touches_sp(y_cls) || (y_dst == SP_L);
    sp_dep    = o_wr_sp && (y_rd_sp || y_wr_sp);
    sp_exempt = (o_cls == CLS_STACK) && (y_cls != CLS_STKIMM);
  end
endmodule

// File: rtl/pair_gate.sv
module pair_gate
  import pair_pkg::*;
(
  input  icls_e o_cls,
  input  icls_e y_cls,
  output logic  blk_branch,
  output logic  blk_complex
);
  always_comb begin
    blk_branch  = (o_cls == CLS_BRANCH);
    blk_complex = (o_cls == CLS_COMPLEX) || (y_cls == CLS_COMPLEX);
  end
endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check
  import pair_pkg::*;
#(
  parameter int REG_W  = 3,
  parameter int SP_IDX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             old_vld,
  input  logic [2:0]       old_cls,
  input  logic [REG_W-1:0] old_dst,
  input  logic [REG_W-1:0] old_srca,
  input  logic [REG_W-1:0] old_srcb,
  input  logic             old_flg_rd,
  input  logic             old_flg_wr,
  input  logic             old_cache,
  input  logic             yng_vld,
  input  logic [2:0]       yng_cls,
  input  logic [REG_W-1:0] yng_dst,
  input  logic [REG_W-1:0] yng_srca,
  input  logic [REG_W-1:0] yng_srcb,
  input  logic             yng_flg_rd,
  input  logic             yng_flg_wr,
  input  logic             yng_cache,
  output logic             pair_o,
  output logic             u_issue_o,
  output logic             v_issue_o,
  output logic [1:0]       consume_o
);
  icls_e oc, yc;
  assign oc = icls_e'(old_cls);
  assign yc = icls_e'(yng_cls);

  logic raw_gp, waw_gp, sp_dep, sp_exempt, blk_branch, blk_complex;
  logic both_vld, sp_block, any_block, pair_d;

  pair_hazard #(.REG_W(REG_W), .SP_IDX(SP_IDX)) u_haz (
    .o_cls(oc), .o_dst(old_dst),
    .y_cls(yc), .y_dst(yng_dst), .y_sa(yng_srca), .y_sb(yng_srcb),
    .raw_gp(raw_gp), .waw_gp(waw_gp), .sp_dep(sp_dep), .sp_exempt(sp_exempt)
  );

  pair_gate u_gate (
    .o_cls(oc), .y_cls(yc),
    .blk_branch(blk_branch), .blk_complex(blk_complex)
  );

  always_comb begin
    both_vld  = old_vld && yng_vld;
    sp_block  = sp_dep && !sp_exempt;
    any_block = blk_branch || blk_complex || raw_gp || waw_gp || sp_block;
    pair_d    = both_vld && !any_block;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_o    <= 1'b0;
      u_issue_o <= 1'b0;
      v_issue_o <= 1'b0;
      consume_o <= 2'd0;
    end else begin
      pair_o    <= pair_d;
      u_issue_o <= old_vld;
      v_issue_o <= pair_d;
      consume_o <= pair_d ? 2'd2 : {1'b0, old_vld};
    end
  end

  AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (!rst_n)
    v_issue_o |-> u_issue_o); // R2
  AST_PAIR_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    pair_o |-> (consume_o == 2'd2 && v_issue_o)); // R2
  AST_RAW_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    raw_gp |=> !pair_o); // R3
  AST_WAW_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    waw_gp |=> !pair_o); // R4
  AST_OLD_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (old_vld && oc == CLS_BRANCH) |=> !pair_o); // R6
  AST_COMPLEX: assert property (@(posedge clk) disable iff (!rst_n)
    blk_complex |=> !pair_o); // R7
  AST_FLAG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (both_vld && !any_block && (old_flg_wr || old_flg_rd) && (yng_flg_rd || yng_flg_wr)) |=> pair_o); // R8
  AST_CACHE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (both_vld && !any_block && old_cache && yng_cache) |=> pair_o); // R9
  AST_SP_UNFORGIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_dep && (oc == CLS_STKIMM || yc == CLS_STKIMM)) |=> !pair_o); // R11
endmodule

// File: tb/pair_issue_check_test.sv
module pair_issue_check_test;
  localparam int REG_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic old_vld, old_flg_rd, old_flg_wr, old_cache;
  logic yng_vld, yng_flg_rd, yng_flg_wr, yng_cache;
  logic [2:0] old_cls, yng_cls;
  logic [REG_W-1:0] old_dst, old_srca, old_srcb, yng_dst, yng_srca, yng_srcb;
  logic pair_o, u_issue_o, v_issue_o;
  logic [1:0] consume_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pair_issue_check #(.REG_W(REG_W), .SP_IDX(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .old_vld(old_vld), .old_cls(old_cls), .old_dst(old_dst), .old_srca(old_srca),
    .old_srcb(old_srcb), .old_flg_rd(old_flg_rd), .old_flg_wr(old_flg_wr), .old_cache(old_cache),
    .yng_vld(yng_vld), .yng_cls(yng_cls), .yng_dst(yng_dst), .yng_srca(yng_srca),
    .yng_srcb(yng_srcb), .yng_flg_rd(yng_flg_rd), .yng_flg_wr(yng_flg_wr), .yng_cache(yng_cache),
    .pair_o(pair_o), .u_issue_o(u_issue_o), .v_issue_o(v_issue_o), .consume_o(consume_o)
  );

  // slot: {vld, cls[2:0], dst[2:0], sa[2:0], sb[2:0], frd, fwr, cache} = 16 bits
  function automatic logic [15:0] S(input logic v, input logic [2:0] c, input logic [2:0] d,
                                    input logic [2:0] a, input logic [2:0] b,
                                    input logic fr, input logic fw, input logic ca);
    return {v, c, d, a, b, fr, fw, ca};
  endfunction

  localparam int NV = 20;
  // entry: {old slot, young slot, expected pair}
  localparam logic [32:0] VEC [NV] = '{
    {S(1,0,1,2,3,0,0,0), S(1,0,5,6,7,0,0,0), 1'b1}, // 0  R2 independent ALUs
    {S(1,0,1,2,3,0,0,0), S(1,0,5,1,7,0,0,0), 1'b0}, // 1  R3 RAW srca
    {S(1,0,1,2,3,0,0,0), S(1,0,5,6,1,0,0,0), 1'b0}, // 2  R3 RAW srcb
    {S(1,0,2,3,3,0,0,0), S(1,0,2,6,7,0,0,0), 1'b0}, // 3  R4 WAW
    {S(1,0,1,5,3,0,0,0), S(1,0,5,6,7,0,0,0), 1'b1}, // 4  R5 WAR
    {S(1,1,0,2,0,0,0,0), S(1,0,5,6,7,0,0,0), 1'b0}, // 5  R6 older branch
    {S(1,0,1,2,3,0,0,0), S(1,1,0,0,0,0,0,0), 1'b1}, // 6  R6 younger branch
    {S(1,0,1,2,3,0,1,0), S(1,1,0,0,0,1,0,0), 1'b1}, // 7  R8 flag dependency
    {S(1,2,0,2,3,0,0,1), S(1,0,5,6,7,0,0,1), 1'b1}, // 8  R9 both cache
    {S(1,3,0,1,0,0,0,0), S(1,3,2,0,0,0,0,0), 1'b1}, // 9  R10 push then pop
    {S(1,3,0,1,0,0,0,0), S(1,4,0,0,0,0,0,0), 1'b0}, // 10 R11 younger imm adjust
    {S(1,0,4,1,0,0,0,0), S(1,3,0,2,0,0,0,0), 1'b0}, // 11 R11 explicit sp write
    {S(1,3,0,5,0,0,0,0), S(1,0,5,4,0,0,0,0), 1'b1}, // 12 R10 push then copy sp
    {S(1,5,1,2,3,0,0,0), S(1,0,5,6,7,0,0,0), 1'b0}, // 13 R7 older complex
    {S(1,0,1,2,3,0,0,0), S(1,5,5,6,7,0,0,0), 1'b0}, // 14 R7 younger complex
    {S(1,0,0,2,3,0,0,0), S(1,0,0,0,0,0,0,0), 1'b1}, // 15 R12 reg zero
    {S(0,0,1,2,3,0,0,0), S(1,0,5,6,7,0,0,0), 1'b0}, // 16 R2 older invalid
    {S(1,0,1,2,3,0,0,0), S(0,0,5,6,7,0,0,0), 1'b0}, // 17 R2 younger invalid
    {S(1,4,0,0,0,0,0,0), S(1,0,1,2,3,0,0,0), 1'b1}, // 18 R11 imm adjust, no sp use after
    {S(1,4,0,0,0,0,0,0), S(1,3,0,1,0,0,0,0), 1'b0}  // 19 R11 imm adjust then push
  };

  task automatic drive(input logic [32:0] v);
    {old_vld, old_cls, old_dst, old_srca, old_srcb, old_flg_rd, old_flg_wr, old_cache} = v[32:17];
    {yng_vld, yng_cls, yng_dst, yng_srca, yng_srcb, yng_flg_rd, yng_flg_wr, yng_cache} = v[16:1];
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    drive(VEC[0]);
    repeat (2) @(negedge clk);
    // R1: in reset with pairable inputs present
    chk("R1 pair", pair_o, 0);
    chk("R1 u", u_issue_o, 0);
    chk("R1 consume", consume_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic ep, eu;
      drive(VEC[i]);
      @(negedge clk);
      ep = VEC[i][0];
      eu = VEC[i][32];
      chk($sformatf("R2 vec%0d pair", i), pair_o, ep);
      chk($sformatf("R2 vec%0d u", i), u_issue_o, eu);
      chk($sformatf("R2 vec%0d v", i), v_issue_o, ep);
      chk($sformatf("R2 vec%0d consume", i), consume_o, ep ? 2 : (eu ? 1 : 0));
    end

    // R8 / R9: toggle every flag and cache bit on a RAW pair; still refused
    drive({S(1,0,1,2,3,1,1,1), S(1,0,5,1,7,1,1,1), 1'b0});
    @(negedge clk);
    chk("R8 R9 side bits on RAW", pair_o, 0);
    // R12: younger reads register zero with older dst zero, WAW on zero too
    drive({S(1,2,0,0,0,0,0,1), S(1,0,0,0,0,0,0,0), 1'b1});
    @(negedge clk);
    chk("R12 zero no dependency", pair_o, 1);

    // R1: asynchronous reset mid-stream clears outputs
    drive(VEC[0]);
    @(negedge clk);
    chk("R1 before reset", pair_o, 1);
    #3 rst_n = 1'b0;
    #2;
    chk("R1 async clear pair", pair_o, 0);
    chk("R1 async clear consume", consume_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 resume", consume_o, 2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule